// File: doc/BRIEF.md
# Framebuffer Control and Status Registers

This block is the byte-wide register bank that a host processor uses to steer a framebuffer controller. It decodes a 32-byte window. One byte holds control flags, among them a frame-interrupt enable. One byte reports status: a pending-interrupt flag plus fixed identification bits that tell software which monitor and board type are fitted. Fourteen more bytes are plain storage that neighbouring logic uses for the cursor and video-control settings.

A display timing generator signals the end of every frame with a one-cycle pulse on `frame_end`. If the interrupt is enabled, that pulse latches a pending flag, and the `irq` line follows the flag. Software acknowledges the interrupt by writing any value to the status offset. The palette offsets in the lower half of the window belong to another block, so this bank reads them as zero and ignores writes to them.

Reads are combinational: `rd_data` shows the register selected by `acc_addr` in the same cycle and has no side effects. A write with `acc_we` high takes effect at the next rising clock edge.

Top module: `fbc_regfile`

## Requirements
- R1: A synchronous active-high reset clears the control byte, the pending flag and all storage bytes. After reset `irq` is 0, offset 0x10 reads 0x00, offset 0x11 reads 0x61 and offsets 0x12 to 0x1F read 0x00.
- R2: Every offset from 0x00 to 0x0F reads 0x00. Writes to those offsets change no register in the bank.
- R3: Offset 0x10 is the control byte. All 8 bits can be written and read back. Bit 7 is the frame-interrupt enable.
- R4: Offset 0x11 reads as the pending flag in bit 7, ORed with the constant 0x61 (monitor sense code 0x60 and colour board bit 0x01).
- R5: A `frame_end` pulse seen while control bit 7 is 1 sets the pending flag at that clock edge. `irq` always equals the pending flag.
- R6: A `frame_end` pulse seen while control bit 7 is 0 leaves the pending flag unchanged.
- R7: A write of any data to offset 0x11 clears the pending flag at that edge, so `irq` falls. The written data is not stored.
- R8: When a `frame_end` pulse with the interrupt enabled and a status write land in the same cycle, the flag ends up set, so a new frame event is not lost.
- R9: Offsets 0x12 to 0x1F are fourteen independent read/write bytes. A write to one changes no other byte.
- R10: Once set, the pending flag and `irq` stay high until a status write, even if the enable bit is cleared.
- R11: A `frame_end` pulse uses the enable value held before the edge. A control write in the same cycle affects only later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_we | input | 1 | Write strobe for the addressed byte |
| acc_addr | input | 5 | Byte offset within the register window |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `acc_addr`, combinational |
| frame_end | input | 1 | One-cycle end-of-frame event |
| irq | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
The hardest cases to reach are collisions within one clock cycle. Examples are a frame event arriving on the same edge as an acknowledge, or on the same edge as a control write that flips the enable. The bench drives these events together on one falling edge, so the design's registers see them on the same rising edge. It then reads `irq` and the status byte on the next falling edge. Address handling is covered by a full sweep: every offset in the window is written with a value computed from the offset, and all 32 offsets are read back afterwards.

// File: rtl/fbc_regs_pkg.sv
package fbc_regs_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int WIN_BYTES = 2 ** ADDR_W;

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT    = 5'h11;
    localparam logic [ADDR_W-1:0] OFF_BANK_LO = 5'h12;

    localparam int BANK_N = WIN_BYTES - int'(OFF_BANK_LO);
    localparam int IDX_W  = $clog2(BANK_N);

    localparam int               IRQ_BIT = 7;
    localparam logic [DATA_W-1:0] STAT_ID = 8'h61;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_BANK
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode_off(input logic [ADDR_W-1:0] a);
        dec_t              d;
        logic [ADDR_W-1:0] diff;
        d.sel = SEL_NONE;
        d.idx = '0;
        diff  = a - OFF_BANK_LO;
        if (a == OFF_CTRL) begin
            d.sel = SEL_CTRL;
        end else if (a == OFF_STAT) begin
            d.sel = SEL_STAT;
        end else if (a >= OFF_BANK_LO) begin
            d.sel = SEL_BANK;
            d.idx = diff[IDX_W-1:0];
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic pend);
        logic [DATA_W-1:0] v;
        v          = STAT_ID;
        v[IRQ_BIT] = pend;
        return v;
    endfunction
endpackage

// File: rtl/fbc_addr_dec.sv
module fbc_addr_dec
    import fbc_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec = decode_off(addr);
    end
endmodule

// File: rtl/fbc_irq_ctl.sv
module fbc_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    logic pend_q;
    logic pend_d;

    always_comb begin
        pend_d = pend_q;
        if (frame_end && enable) begin
            pend_d = 1'b1;
        end else if (ack) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_end && enable) |=> pending);
    p_noset_r6: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(frame_end && enable)) |=> !pending);
    p_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && !frame_end) |=> !pending);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack) |=> pending);
endmodule

// File: rtl/fbc_byte_bank.sv
module fbc_byte_bank #(
    parameter int N = 14,
    parameter int W = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [N-1:0][W-1:0] mem;

    for (genvar g = 0; g < N; g++) begin : g_byte
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (int'(idx) == g)) begin
                q <= wdata;
            end
        end
        assign mem[g] = q;
    end

    always_comb begin
        rdata = '0;
        if (int'(idx) < N) begin
            rdata = mem[idx];
        end
    end

    p_keep_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem));
endmodule

// File: rtl/fbc_regfile.sv
module fbc_regfile
    import fbc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    output logic              irq
);
    dec_t              dec;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] bank_rd;
    logic              pending;
    logic              ack;
    logic              bank_we;

    fbc_addr_dec u_dec (
        .addr (acc_addr),
        .dec  (dec)
    );

    assign ack     = acc_we && (dec.sel == SEL_STAT);
    assign bank_we = acc_we && (dec.sel == SEL_BANK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (acc_we && (dec.sel == SEL_CTRL)) begin
            ctrl_q <= acc_wdata;
        end
    end

    fbc_irq_ctl u_irq (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .enable    (ctrl_q[IRQ_BIT]),
        .ack       (ack),
        .pending   (pending)
    );

    fbc_byte_bank #(
        .N (BANK_N),
        .W (DATA_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .idx   (dec.idx),
        .wdata (acc_wdata),
        .rdata (bank_rd)
    );

    always_comb begin
        case (dec.sel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_STAT: rd_data = status_word(pending);
            SEL_BANK: rd_data = bank_rd;
            default:  rd_data = '0;
        endcase
    end

    assign irq = pending;

    p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_addr < OFF_CTRL) |-> (rd_data == '0));
    p_ctrl_wr_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_we && acc_addr == OFF_CTRL) |=> (ctrl_q == $past(acc_wdata)));
    p_stat_id_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == OFF_STAT) |-> ((rd_data & 8'h7F) == STAT_ID));
    p_collide_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && frame_end && ctrl_q[IRQ_BIT]) |=> irq);
endmodule

// File: tb/fbc_regfile_bench.sv
module fbc_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_we;
    logic [4:0] acc_addr;
    logic [7:0] acc_wdata;
    logic [7:0] rd_data;
    logic       frame_end;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fbc_regfile u_fbc_regfile (
        .clk       (clk),
        .rst       (rst),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_data   (rd_data),
        .frame_end (frame_end),
        .irq       (irq)
    );

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 37 + 5 + salt * 11) & 8'hFF);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        acc_addr = a;
        #1 v = rd_data;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic frame_with_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        frame_end = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        frame_end = 1'b0; acc_we = 1'b0;
    endtask

    task automatic chk_irq(input string req, input logic exp);
        logic [7:0] s;
        #1;
        chk(req, int'(irq), int'(exp));
        rd(5'h11, s);
        chk(req, int'(s), exp ? 8'hE1 : 8'h61);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0; frame_end = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state of every offset
        #1 chk("R1 irq", int'(irq), 0);
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            chk("R1 read", int'(v), (a == 17) ? 8'h61 : 8'h00);
        end

        // Full window sweep: R2, R3, R9
        for (int a = 0; a < 32; a++) begin
            if (a != 17) wr(5'(a), pat(a, 0));
        end
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            if (a < 16)       chk("R2 low offset", int'(v), 0);
            else if (a == 16) chk("R3 ctrl", int'(v), int'(pat(a, 0)));
            else if (a == 17) chk("R4 status idle", int'(v), 8'h61);
            else              chk("R9 bank byte", int'(v), int'(pat(a, 0)));
        end

        // R9 single-byte write leaves neighbours alone
        for (int t = 18; t < 32; t++) begin
            wr(5'(t), pat(t, 1));
            for (int a = 18; a < 32; a++) begin
                rd(5'(a), v);
                chk("R9 isolation", int'(v), int'(a <= t ? pat(a, 1) : pat(a, 0)));
            end
        end

        // R2 writes to low offsets leave ctrl and bank unchanged
        for (int a = 0; a < 16; a++) wr(5'(a), 8'hFF);
        rd(5'h10, v); chk("R2 ctrl kept", int'(v), int'(pat(16, 0)));
        rd(5'h1F, v); chk("R2 bank kept", int'(v), int'(pat(31, 1)));

        // R3 every control value
        for (int d = 0; d < 256; d++) begin
            wr(5'h10, 8'(d));
            rd(5'h10, v);
            chk("R3 ctrl value", int'(v), d);
        end

        // R6 frame with enable clear
        wr(5'h10, 8'h7F);
        frame();
        chk_irq("R6 disabled frame", 1'b0);

        // R5 frame with enable set
        wr(5'h10, 8'h80);
        frame();
        chk_irq("R5 enabled frame", 1'b1);

        // R10 hold after enable cleared
        wr(5'h10, 8'h00);
        repeat (5) @(negedge clk);
        chk_irq("R10 hold", 1'b1);

        // R7 ack with arbitrary data, data not stored
        wr(5'h11, 8'h00);
        chk_irq("R7 ack", 1'b0);
        wr(5'h10, 8'h80);
        frame();
        chk_irq("R5 second frame", 1'b1);
        wr(5'h11, 8'hFF);
        chk_irq("R7 ack data ignored", 1'b0);
        wr(5'h11, 8'h80);
        chk_irq("R7 ack when idle", 1'b0);

        // R8 frame and ack in same cycle
        frame_with_wr(5'h11, 8'h5A);
        chk_irq("R8 collision from idle", 1'b1);
        frame_with_wr(5'h11, 8'hA5);
        chk_irq("R8 collision while pending", 1'b1);
        wr(5'h11, 8'h00);
        chk_irq("R7 ack after collision", 1'b0);

        // R11 enable sampled before same-cycle control write
        wr(5'h10, 8'h00);
        frame_with_wr(5'h10, 8'h80);
        chk_irq("R11 enable not yet active", 1'b0);
        frame_with_wr(5'h10, 8'h00);
        chk_irq("R11 old enable used", 1'b1);

        // R1 reset while pending
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk_irq("R1 reset clears pending", 1'b0);
        rd(5'h10, v); chk("R1 ctrl after reset", int'(v), 0);
        rd(5'h12, v); chk("R1 bank after reset", int'(v), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule